// File: doc/BRIEF.md
# Programmable Periodic Soft Trigger Generator

This block emits an endless train of one-cycle trigger pulses, synchronous to the system clock, while its run input is held high. The spacing between pulses is not a free divider value. It is a fixed base of two steps plus one step for each unit of an 8-bit rate setting N. One step is 12.5 ms, which is CLK_HZ/80 clock cycles. N = 0 therefore gives a 25 ms interval (40 Hz), and N = 255 stretches it to 3212.5 ms (about 0.3 Hz).

The rate setting arrives as a 16-bit word on a valid/ready command stream. Only words whose upper byte is the rate opcode 0x21 change the setting, and their lower byte becomes N. There is no back-pressure. Once reset is released, `cmd_ready` stays high and a word is taken on every cycle where `cmd_valid` is high. A newly accepted setting waits until the interval in progress has finished, so a running interval is never cut short. Dropping `run` clears the timing state. Raising it again starts a complete new interval before the first pulse.

Top module: `soft_trig_gen`

## Requirements
- R1: A command word accepted (`cmd_valid` and `cmd_ready` high at a rising edge) with bits [15:8] equal to 0x21 stores bits [7:0] as the pending rate setting N.
- R2: While `run` stays high, consecutive pulses are exactly (2 + N) × (CLK_HZ/80) clock cycles apart. This holds at both N = 0 and N = 255.
- R3: Each pulse on `trig` lasts exactly one clock cycle. Pulses keep repeating for as long as `run` stays high.
- R4: If `run` is first sampled high at rising edge k, the first pulse is visible in the cycle after edge k + P − 1, where P is the interval in cycles. A cycle-counting bench sees it P cycles after the cycle in which `run` was raised.
- R5: A setting accepted during an interval does not change that interval. The intervals after the next pulse use the new setting.
- R6: While `run` is low, no pulse appears and the interval timing is cleared. This includes a pulse that would have been due on the first edge at which `run` is sampled low.
- R7: An accepted command word whose bits [15:8] are not 0x21 leaves the rate setting unchanged.
- R8: During reset, `trig` and `cmd_ready` are low. After reset, N is 0 and no pulses appear until `run` is raised.
- R9: From the first rising edge after reset is released, `cmd_ready` is high on every cycle. No command word is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run enable for the pulse train |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Command word accepted when high with cmd_valid |
| cmd_data | input | 16 | Command word: [15:8] opcode, [7:0] rate setting |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The bench builds the block with CLK_HZ = 800, so one step is 10 cycles. The 25 ms base interval becomes 20 cycles, and the slowest setting, N = 255, becomes 2570 cycles. At that scale the full rate range, mid-interval rate changes, a disable landing on the cycle before a due pulse, and several intervals at the slowest rate all fit easily in one short run. The default CLK_HZ would need over 64 million cycles for a single slow interval.

// File: rtl/soft_trig_pkg.sv
package soft_trig_pkg;
  localparam int          RATE_W      = 8;
  localparam int          OPC_W       = 8;
  localparam logic [7:0]  RATE_OPCODE = 8'h21;
  localparam int          BASE_STEPS  = 2;
  localparam int          STEPS_PER_S = 80;
  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/soft_trig_cmd.sv
module soft_trig_cmd
  import soft_trig_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             cmd_ready,
  output rate_t            rate_pend
);
  localparam int OPC_LSB = CMD_W - OPC_W;

  logic rdy_q;
  logic take;
  logic opc_hit;

  assign cmd_ready = rdy_q;
  assign take      = cmd_valid && rdy_q;
  assign opc_hit   = (cmd_data[CMD_W-1:OPC_LSB] == RATE_OPCODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      rate_pend <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (take && opc_hit) rate_pend <= cmd_data[RATE_W-1:0];
    end
  end

  AST_RATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_data[CMD_W-1:OPC_LSB] == RATE_OPCODE)
      |=> (rate_pend == $past(cmd_data[RATE_W-1:0]))); // R1
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_data[CMD_W-1:OPC_LSB] != RATE_OPCODE) |=> $stable(rate_pend)); // R7
endmodule

// File: rtl/soft_trig_prescale.sv
module soft_trig_prescale #(
  parameter int STEP_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (STEP_CYC <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int SW = $clog2(STEP_CYC);
      localparam logic [SW-1:0] LAST = SW'(STEP_CYC - 1);
      logic [SW-1:0] cnt;

      assign tick = run && (cnt == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end

      AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R2
      AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R6
    end
  endgenerate
endmodule

// File: rtl/soft_trig_timer.sv
module soft_trig_timer
  import soft_trig_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  tick,
  input  rate_t rate_pend,
  output logic  trig
);
  localparam int UW = RATE_W + 1;

  rate_t         cur_n;
  logic [UW-1:0] unit;
  logic [UW-1:0] last_unit;
  logic          wrap;

  assign last_unit = {1'b0, cur_n} + UW'(BASE_STEPS - 1);
  assign wrap      = tick && (unit == last_unit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit  <= '0;
      cur_n <= '0;
      trig  <= 1'b0;
    end else if (!run) begin
      unit  <= '0;
      cur_n <= rate_pend;
      trig  <= 1'b0;
    end else if (wrap) begin
      unit  <= '0;
      cur_n <= rate_pend;
      trig  <= 1'b1;
    end else begin
      if (tick) unit <= unit + 1'b1;
      trig <= 1'b0;
    end
  end

  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    unit <= last_unit); // R2
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (unit != '0) |-> $stable(cur_n)); // R5
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !trig); // R6
endmodule

// File: rtl/soft_trig_gen.sv
module soft_trig_gen
  import soft_trig_pkg::*;
#(
  parameter int CLK_HZ = 20_000_000,
  parameter int CMD_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CMD_W-1:0] cmd_data,
  output logic             trig
);
  localparam int STEP_CYC = CLK_HZ / STEPS_PER_S;

  rate_t rate_pend;
  logic  tick;

  soft_trig_cmd #(.CMD_W(CMD_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .rate_pend (rate_pend)
  );

  soft_trig_prescale #(.STEP_CYC(STEP_CYC)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  soft_trig_timer u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .rate_pend (rate_pend),
    .trig      (trig)
  );

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R3
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cmd_ready); // R9
endmodule

// File: tb/tb_soft_trig_gen.sv
`timescale 1ns/1ps
module tb_soft_trig_gen;
  localparam int CLK_HZ = 800;
  localparam int STEP   = CLK_HZ / 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_ready;
  logic        trig;

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  int    exp_q[$];
  string req_q[$];
  bit    done = 1'b0;

  soft_trig_gen #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .trig(trig)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_pulse(input int at, input string req);
    exp_q.push_back(at);
    req_q.push_back(req);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = '0;
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    req_q.delete();
  endtask

  // monitor: every pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && trig) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected pulse", cyc, -1);
      end else begin
        int    e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(cyc == e, r, cyc, e);
      end
    end
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    check(trig == 1'b0, "R8 trig in reset", trig, 0);
    check(cmd_ready == 1'b0, "R8 ready in reset", cmd_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R9 ready after reset", cmd_ready, 1);

    // R8: idle after reset, foreign opcodes (R7) before enabling
    repeat (60) @(negedge clk);
    send(16'h2203);
    send(16'hFF21);
    check(cmd_ready == 1'b1, "R9 ready stays high", cmd_ready, 1);
    drained("R8 no pulse while idle");

    // R2/R3/R4 with N=0 (20 cycles), R7 N unchanged
    @(negedge clk);
    c = cyc; run = 1'b1;
    expect_pulse(c + 2*STEP, "R4 first pulse N=0");
    expect_pulse(c + 4*STEP, "R2 interval N=0");
    expect_pulse(c + 6*STEP, "R3 repeat N=0 / R7");
    wait_until(c + 65);
    // R1/R5: new rate mid-interval
    send(16'h2102);
    expect_pulse(c + 80,  "R5 interval kept at old rate");
    expect_pulse(c + 120, "R1 new rate N=2");
    expect_pulse(c + 160, "R2 interval N=2");
    wait_until(c + 170);
    run = 1'b0;
    wait_until(c + 210);
    drained("R6 no pulse while disabled");

    // re-enable: fresh full interval, foreign word mid-run (R7)
    c = cyc; run = 1'b1;
    expect_pulse(c + 40, "R4 fresh interval after re-enable");
    expect_pulse(c + 80, "R7 foreign word ignored");
    wait_until(c + 10);
    send(16'h3005);
    wait_until(c + 90);
    run = 1'b0;
    drained("R3 pulse count while running");

    // R6: disable on the cycle before a due pulse
    @(negedge clk);
    c = cyc; run = 1'b1;
    wait_until(c + 39);
    run = 1'b0;
    wait_until(c + 100);
    check(trig == 1'b0, "R6 trig low after late disable", trig, 0);
    drained("R6 due pulse suppressed");

    // R2 slowest setting
    send(16'h21FF);
    @(negedge clk);
    c = cyc; run = 1'b1;
    expect_pulse(c + 257*STEP,   "R2 first pulse N=255");
    expect_pulse(c + 2*257*STEP, "R2 interval N=255");
    wait_until(c + 2*257*STEP + 5);
    run = 1'b0;
    drained("R2 slow pulses seen");

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule